// File: doc/BRIEF.md
# MDIO Management Command Controller

The block is an MDIO master that lets a host reach the management registers of an Ethernet PHY through two 16-bit registers. The host first loads a data word, then writes a command word that carries a write-request bit, a read-request bit, a 5-bit PHY address and a 5-bit register number. The block then sends a Clause 22 management frame on MDC/MDIO. For a read, it captures the returned word into a read-data register.

The request bit in the command word reads back as set for as long as the frame is in flight. It drops on its own when the transfer ends, so software only has to poll the command register to know when it can continue. MDC comes from the system clock through a parameterised divider, and it rests low whenever the block is idle.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, all four host addresses read 0, and mdc_o, mdio_o and mdio_oe_o are low.
- R2: Host address 0 is the command register. Bit 14 requests a write, bit 13 requests a read, bits 12:8 hold the PHY address and bits 4:0 hold the register number. A command with neither request bit set starts nothing and leaves the command readback unchanged.
- R3: Each frame is 64 MDC periods long and is sent MSB first: 32 ones, start bits 01, opcode 01 for a write or 10 for a read, the PHY address, then the register number.
- R4: A write frame ends with turnaround bits 10 followed by the 16-bit word held at host address 1. mdio_oe_o stays high for all 64 bits.
- R5: A read frame releases mdio_oe_o from bit 46 (the turnaround) to the end of the frame. It samples the 16 data bits on rising MDC edges, MSB first, and the word then reads back at host address 2.
- R6: MDC is high and low for CLK_DIV system clocks each, and stays low while idle. mdio_o and mdio_oe_o change only at falling MDC edges or at the start of a frame.
- R7: The request bit reads back as 1 for exactly 128*CLK_DIV clocks after the command is accepted, then clears. The PHY address and register fields remain readable afterwards.
- R8: A command written while a transfer is in progress is ignored. This includes a write in the clock where the last falling MDC edge occurs. The frame and the readback fields are unaffected.
- R9: If both request bits are set, the command is performed as a write.
- R10: The write word is captured when the command is accepted. Rewriting host address 1 during a transfer changes the readback of that register but not the data bits on the wire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 2 | Host register address (0 command, 1 write data, 2 read data) |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Host readback of the addressed register (combinational) |
| mdio_i | input | 1 | MDIO line input |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
Two events can fall in the same clock: a host command write and the final falling MDC edge, which clears the busy state. The bench provokes this by holding a new command write asserted on every clock through the end of a running frame. The result is judged from the command readback, which must show the idle state in exactly one sample before the new command is taken. The two MDC frames seen on the wire must also carry the first command and then the second, with no bit of the second leaking into the first.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int unsigned PHY_W     = 5;
  localparam int unsigned REG_W     = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned PRE_LEN   = 32;
  localparam int unsigned TA_POS    = PRE_LEN + 4 + PHY_W + REG_W;
  localparam int unsigned DATA_POS  = TA_POS + 2;
  localparam int unsigned FRAME_LEN = DATA_POS + DATA_W;
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  localparam int unsigned CMD_WR_BIT = 14;
  localparam int unsigned CMD_RD_BIT = 13;
  localparam int unsigned CMD_PHY_LO = 8;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  typedef enum logic [1:0] {
    ADDR_CMD   = 2'd0,
    ADDR_WDATA = 2'd1,
    ADDR_RDATA = 2'd2,
    ADDR_NONE  = 2'd3
  } host_addr_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             wrap;

  assign wrap = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_rd_i,
  input  logic [PHY_W-1:0]  phy_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdi_i,
  output logic              busy_o,
  output logic              is_rd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(TA_POS);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_POS);

  logic                 busy_q, rd_q, oe_q;
  logic [IDX_W-1:0]     idx_q, idx_nxt;
  logic [FRAME_LEN-1:0] tx_q, frame;
  logic [DATA_W-1:0]    rx_q;
  logic                 last_bit;

  always_comb begin
    if (start_rd_i)
      frame = {{PRE_LEN{1'b1}}, SOF_BITS, OP_RD, phy_i, reg_i, 2'b00, {DATA_W{1'b0}}};
    else
      frame = {{PRE_LEN{1'b1}}, SOF_BITS, OP_WR, phy_i, reg_i, TA_WR, wdata_i};
  end

  assign idx_nxt  = idx_q + 1'b1;
  assign last_bit = (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      rd_q   <= start_rd_i;
      oe_q   <= 1'b1;
      idx_q  <= '0;
      tx_q   <= frame;
      rx_q   <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && (idx_q >= IDX_DATA))
        rx_q <= {rx_q[DATA_W-2:0], mdi_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          tx_q   <= '0;
        end else begin
          idx_q <= idx_nxt;
          tx_q  <= {tx_q[FRAME_LEN-2:0], 1'b0};
          // release the line from turnaround onward on reads
          oe_q  <= !(rd_q && (idx_nxt >= IDX_TA));
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign is_rd_o = rd_q;
  assign idx_o   = idx_q;
  assign mdo_o   = tx_q[FRAME_LEN-1];
  assign oe_o    = oe_q;
  assign done_o  = busy_q && fall_i && last_bit;
  assign rdata_o = rx_q;
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              busy_i,
  input  logic              is_rd_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] eng_rdata_i,
  output logic              start_o,
  output logic              start_rd_o,
  output logic [PHY_W-1:0]  phy_o,
  output logic [REG_W-1:0]  reg_o,
  output logic [DATA_W-1:0] wdat_o
);
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              cmd_sel, req_wr, req_rd;
  host_addr_e        sel;

  assign sel     = host_addr_e'(addr_i);
  assign cmd_sel = we_i && (sel == ADDR_CMD);
  assign req_wr  = wdata_i[CMD_WR_BIT];
  assign req_rd  = wdata_i[CMD_RD_BIT];
  assign start_o    = cmd_sel && (req_wr || req_rd) && !busy_i;
  assign start_rd_o = req_rd && !req_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_q  <= '0;
      reg_q  <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      if (start_o) begin
        phy_q <= wdata_i[CMD_PHY_LO +: PHY_W];
        reg_q <= wdata_i[REG_W-1:0];
      end
      if (we_i && (sel == ADDR_WDATA))
        wdat_q <= wdata_i;
      if (done_i && is_rd_i)
        rdat_q <= eng_rdata_i;
    end
  end

  always_comb begin
    unique case (sel)
      ADDR_CMD:   rdata_o = {1'b0, busy_i && !is_rd_i, busy_i && is_rd_i, phy_q, 3'b000, reg_q};
      ADDR_WDATA: rdata_o = wdat_q;
      ADDR_RDATA: rdata_o = rdat_q;
      default:    rdata_o = '0;
    endcase
  end

  assign phy_o  = wdata_i[CMD_PHY_LO +: PHY_W];
  assign reg_o  = wdata_i[REG_W-1:0];
  assign wdat_o = wdat_q;
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic              busy, is_rd, done, start, start_rd;
  logic              rise, fall;
  logic [IDX_W-1:0]  idx;
  logic [PHY_W-1:0]  phy_in;
  logic [REG_W-1:0]  reg_in;
  logic [DATA_W-1:0] wdat, eng_rdata;

  mdio_host_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .is_rd_i     (is_rd),
    .done_i      (done),
    .eng_rdata_i (eng_rdata),
    .start_o     (start),
    .start_rd_o  (start_rd),
    .phy_o       (phy_in),
    .reg_o       (reg_in),
    .wdat_o      (wdat)
  );

  mdio_clk_gen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .start_rd_i (start_rd),
    .phy_i      (phy_in),
    .reg_i      (reg_in),
    .wdata_i    (wdat),
    .rise_i     (rise),
    .fall_i     (fall),
    .mdi_i      (mdio_i),
    .busy_o     (busy),
    .is_rd_o    (is_rd),
    .idx_o      (idx),
    .mdo_o      (mdio_o),
    .oe_o       (mdio_oe_o),
    .done_o     (done),
    .rdata_o    (eng_rdata)
  );
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk
  import mdio_cmd_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mdc_o,
  input logic             mdio_o,
  input logic             mdio_oe_o,
  input logic             busy,
  input logic             is_rd,
  input logic [IDX_W-1:0] idx,
  input logic [15:0]      reg_rdata_o,
  input logic [1:0]       reg_addr_i
);
  int unsigned hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= 0;
    else if (mdc_o) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= 0;
  end

  p_idle_mdc_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  p_hold_while_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_high_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> (hi_cnt == CLK_DIV));

  p_read_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && is_rd && (idx >= IDX_W'(TA_POS))) |-> !mdio_oe_o);

  p_write_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !is_rd) |-> mdio_oe_o);

  p_pend_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> $onehot0(reg_rdata_o[14:13]));

  p_idle_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdio_oe_o);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o),
  .busy        (busy),
  .is_rd       (is_rd),
  .idx         (idx),
  .reg_rdata_o (reg_rdata_o),
  .reg_addr_i  (reg_addr_i)
);

// File: tb/mdio_cmd_ctrl_tb_top.sv
module mdio_cmd_ctrl_tb_top;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdat = 16'h0;
  logic [15:0] rdat;
  logic        mdio_in = 1'b1;
  logic        mdc, mdo, oe;

  mdio_cmd_ctrl #(.CLK_DIV(CLK_DIV)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdat),
    .reg_rdata_o (rdat),
    .mdio_i      (mdio_in),
    .mdc_o       (mdc),
    .mdio_o      (mdo),
    .mdio_oe_o   (oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int          rise_cnt = 0;
  logic        mon_d  [128];
  logic        mon_oe [128];
  logic [15:0] rsp_val = 16'h0;

  // bus monitor: PHY samples on rising MDC
  always @(posedge mdc) begin
    if (rise_cnt < 128) begin
      mon_d[rise_cnt]  = mdo;
      mon_oe[rise_cnt] = oe;
    end
    rise_cnt++;
  end

  // PHY responder: drives next bit after falling MDC
  always @(negedge mdc) begin
    int n;
    n = rise_cnt % 64;
    if (n >= 48) mdio_in = rsp_val[63-n];
    else mdio_in = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdat = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdat;
  endtask

  function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] ph, input logic [4:0] rg,
                                            input logic [15:0] d);
    if (wr) return {32'hFFFF_FFFF, 2'b01, 2'b01, ph, rg, 2'b10, d};
    return {32'hFFFF_FFFF, 2'b01, 2'b10, ph, rg, 2'b00, 16'h0};
  endfunction

  function automatic logic [63:0] exp_oe(input bit wr);
    return wr ? 64'hFFFF_FFFF_FFFF_FFFF : 64'hFFFF_FFFF_FFFC_0000;
  endfunction

  function automatic logic [63:0] got_bits(input int base, input bit want_oe);
    logic [63:0] r;
    for (int k = 0; k < 64; k++) r[63-k] = want_oe ? mon_oe[base+k] : mon_d[base+k];
    return r;
  endfunction

  task automatic run_txn(input logic [1:0] req, input logic [4:0] ph, input logic [4:0] rg,
                         input logic [15:0] d, input logic [15:0] rsp, input int mid);
    logic [15:0] v, cmd;
    logic [63:0] ef, eo, m;
    int pend;
    bit wr;
    wr = req[1];
    pend = 0;
    cmd = {1'b0, req, ph, 3'b000, rg};
    host_write(2'd1, d);
    rise_cnt = 0;
    rsp_val = rsp;
    host_write(2'd0, cmd);
    rd(2'd0, v);
    while (v[14] | v[13]) begin
      pend++;
      if (pend == 200 && mid == 1) begin
        we = 1'b1; addr = 2'd0; wdat = {1'b0, 2'b10, ~ph, 3'b000, ~rg};
        @(negedge clk);
        we = 1'b0;
        rd(2'd0, v);
        check(v == {1'b0, wr, !wr, ph, 3'b000, rg}, "R8 command ignored while busy", 64'(v),
              64'({1'b0, wr, !wr, ph, 3'b000, rg}));
      end else if (pend == 200 && mid == 2) begin
        we = 1'b1; addr = 2'd1; wdat = ~d;
        @(negedge clk);
        we = 1'b0;
        rd(2'd0, v);
      end else begin
        @(negedge clk);
        rd(2'd0, v);
      end
    end
    check(pend == 128*CLK_DIV, "R7 busy duration", 64'(pend), 64'(128*CLK_DIV));
    check(rise_cnt == 64, "R6 MDC rising edges per frame", 64'(rise_cnt), 64'd64);
    ef = exp_frame(wr, ph, rg, d);
    eo = exp_oe(wr);
    m  = exp_oe(wr);
    check((got_bits(0, 1'b0) & m) == (ef & m), wr ? "R3 R4 write frame bits" : "R3 read frame bits",
          got_bits(0, 1'b0) & m, ef & m);
    check(got_bits(0, 1'b1) == eo, wr ? "R4 write output enable" : "R5 read output enable",
          got_bits(0, 1'b1), eo);
    check(v == {1'b0, 2'b00, ph, 3'b000, rg}, "R7 readback after completion", 64'(v),
          64'({1'b0, 2'b00, ph, 3'b000, rg}));
    if (!wr) begin
      rd(2'd2, v);
      check(v == rsp, "R5 read data register", 64'(v), 64'(rsp));
    end
    if (mid == 2) begin
      rd(2'd1, v);
      check(v == ~d, "R10 write-data readback updated", 64'(v), 64'(~d));
    end
    addr = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, prev, dd;
    logic [4:0] phs [4];
    logic [4:0] rgs [4];
    int idle;
    phs[0] = 5'd0; phs[1] = 5'd1; phs[2] = 5'd21; phs[3] = 5'd31;
    rgs[0] = 5'd0; rgs[1] = 5'd5; rgs[2] = 5'd18; rgs[3] = 5'd31;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 16'h0, "R1 register reset value", 64'(v), 64'h0);
    end
    check({mdc, mdo, oe} == 3'b000, "R1 line outputs after reset", 64'({mdc, mdo, oe}), 64'h0);

    // sweep of both operations over addresses and registers
    for (int op = 0; op < 2; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++) begin
          dd = 16'((int'(phs[i]) * 16'h1357) ^ (int'(rgs[j]) * 16'h0F0F) ^ 16'hA5C3);
          run_txn(op == 0 ? 2'b10 : 2'b01, phs[i], rgs[j], dd, ~dd ^ 16'h00FF, 0);
        end

    // R2 command without a request bit
    rd(2'd0, prev);
    rise_cnt = 0;
    host_write(2'd0, 16'h9F1F);
    repeat (40) @(negedge clk);
    rd(2'd0, v);
    check(v == prev, "R2 no-request command leaves readback", 64'(v), 64'(prev));
    check(rise_cnt == 0, "R2 no-request command starts no frame", 64'(rise_cnt), 64'h0);

    // R9 both request bits
    run_txn(2'b11, 5'd9, 5'd3, 16'h3C5A, 16'h1234, 0);
    // R8 command during a read
    run_txn(2'b01, 5'd17, 5'd22, 16'h0, 16'hBEEF, 1);
    // R8 command during a write
    run_txn(2'b10, 5'd6, 5'd12, 16'h8001, 16'h0, 1);
    // R10 write-data rewrite during a write
    run_txn(2'b10, 5'd26, 5'd7, 16'h5AA5, 16'h0, 2);

    // R8 collision: command held through the final falling MDC edge
    host_write(2'd1, 16'hC3E1);
    rise_cnt = 0;
    host_write(2'd0, {1'b0, 2'b10, 5'd3, 3'b000, 5'd9});
    idle = 0;
    we = 1'b1; addr = 2'd0; wdat = {1'b0, 2'b10, 5'd28, 3'b000, 5'd17};
    rd(2'd0, v);
    while (!(v[14] && v[12:8] == 5'd28)) begin
      if (!(v[14] | v[13])) idle++;
      @(negedge clk);
      rd(2'd0, v);
    end
    we = 1'b0;
    check(idle == 1, "R8 idle samples at completion collision", 64'(idle), 64'd1);
    while (v[14] | v[13]) begin
      @(negedge clk);
      rd(2'd0, v);
    end
    check(rise_cnt == 128, "R8 two frames back to back", 64'(rise_cnt), 64'd128);
    check(got_bits(0, 1'b0) == exp_frame(1'b1, 5'd3, 5'd9, 16'hC3E1), "R8 first frame intact",
          got_bits(0, 1'b0), exp_frame(1'b1, 5'd3, 5'd9, 16'hC3E1));
    check(got_bits(64, 1'b0) == exp_frame(1'b1, 5'd28, 5'd17, 16'hC3E1), "R8 second frame",
          got_bits(64, 1'b0), exp_frame(1'b1, 5'd28, 5'd17, 16'hC3E1));
    check({mdc, oe} == 2'b00, "R6 line idle after frames", 64'({mdc, oe}), 64'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule